// File: doc/BRIEF.md
# Quad-Lane Serial Flash Command Sequencer

This block runs a single serial-flash command on a bus of one, two or four data lanes. A command has up to four phases: an opcode, an address, a stretch of idle turnaround clocks, and a data transfer. They always run in that order. A phase whose lane code is zero is left out. Each phase that runs picks its own lane count, so one command can, for example, send a single-lane opcode, a four-lane address and four-lane read data.

Software programs four registers through a simple write port: control, command word, address and data length. The serial clock is derived from the system clock by a programmable divider. A control bit selects which of two chip-select outputs is driven low. Bytes to be written are taken from an external first-word-fall-through FIFO by a pop strobe. Bytes read from the flash are handed out with a push strobe.

Top module: `qspi_cmd_seq`

## Requirements
- R1: After reset both chip selects are high, the serial clock is low, busy is low and no lane is driven (`io_oe` = 0).
- R2: Register select codes are 0 = control, 1 = command, 2 = address, 3 = data length. Command bits 27:26 give the mode: 0 = write, 1 = read; 2 and 3 never start a command. A valid command with address lane code (bits 11:10) zero starts when the command word is written. With a nonzero address lane code it starts only when the address register is written.
- R3: The phases that run follow the order opcode, address, turnaround, data. Opcode lane code is bits 9:8 and data lane code is bits 25:24. A phase with lane code 0, or a turnaround count of 0, is skipped.
- R4: Lane code 1 sends on `io_out[0]` and receives on `io_in[1]`. Code 2 uses lanes 1:0 and code 3 uses lanes 3:0, with the higher lane carrying the more significant bit. Bits go out MSB first, one group per serial clock, and are stable across each rising edge.
- R5: The opcode is command bits 7:0. Command bits 13:12 hold the address byte count minus one. The low-order address bytes are sent, most significant first.
- R6: The turnaround phase lasts the number of serial clocks in command bits 22:18, with all lanes released.
- R7: In write mode the data phase sends data-length+1 bytes, popping the FIFO exactly once per byte.
- R8: In read mode the data phase releases all lanes and pushes data-length+1 assembled bytes, MSB first.
- R9: With prescaler P in control bits 31:24, the serial clock period is P+1 system clocks, with P=0 treated as 1. The serial clock stays low whenever the block is idle.
- R10: Control bit 7 = 0 drives `cs_n[0]` low for the command, and 1 drives `cs_n[1]` low. The other select stays high.
- R11: Control bit 4 moves input sampling from the rising serial edge to the end of the clock period. The bytes read from a device that changes its data on falling edges are unchanged.
- R12: The chip select returns high P+1 system clocks (one serial period) after the last falling edge of the serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 control, 1 command, 2 address, 3 length) |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | Command in progress |
| sclk | output | 1 | Serial clock |
| cs_n | output | 2 | Active-low chip selects |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |
| tx_pop | output | 1 | Pop strobe to the write FIFO |
| tx_data | input | 8 | Head byte of the write FIFO |
| rx_push | output | 1 | Read byte valid strobe |
| rx_data | output | 8 | Read byte |

## Verification
A command starts two system clocks after the starting register write: one cycle for the write and one for the registered start pulse. Its lane values are then due at each rising serial edge, so the bench records lanes, enables and chip selects on `sclk` rising edges and compares the whole stream against one built from the requirements, without counting system cycles. The model flash changes its read data just after each falling serial edge, which puts it ahead of both sampling points. The clock period and the chip-select release are measured as time differences: between two rising edges, and from the last falling edge to the chip-select rise. Those differences must equal P+1 system clocks. FIFO pops and read pushes are counted on system clock edges once busy has dropped.

// File: rtl/qspi_seq_pkg.sv
`timescale 1ns/1ps
package qspi_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_INSTR, PH_ADDR, PH_DUMMY, PH_DATA, PH_TAIL
  } phase_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_CMD  = 2'd1;
  localparam logic [1:0] SEL_ADDR = 2'd2;
  localparam logic [1:0] SEL_LEN  = 2'd3;

  // lane code -> log2 of bits per serial clock
  function automatic logic [1:0] lanes_log2(input logic [1:0] code);
    case (code)
      2'd2:    return 2'd1;
      2'd3:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  // first enabled phase strictly after cur
  function automatic phase_e next_phase(input phase_e cur, input logic [31:0] cmd);
    if (cur == PH_IDLE && cmd[9:8] != 2'd0) return PH_INSTR;
    if ((cur == PH_IDLE || cur == PH_INSTR) && cmd[11:10] != 2'd0) return PH_ADDR;
    if ((cur == PH_IDLE || cur == PH_INSTR || cur == PH_ADDR) && cmd[22:18] != 5'd0)
      return PH_DUMMY;
    if (cur != PH_DATA && cur != PH_TAIL && cmd[25:24] != 2'd0) return PH_DATA;
    return PH_TAIL;
  endfunction

endpackage

// File: rtl/qspi_seq_clkgen.sv
`timescale 1ns/1ps
module qspi_seq_clkgen #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               gate_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               rise_o,
  output logic               end_o,
  output logic               sclk_o
);
  logic [PRESC_W-1:0] cnt_q, cnt_d, presc_eff;
  logic [PRESC_W:0]   half;
  logic               sclk_q, sclk_d;

  assign presc_eff = (presc_i == '0) ? PRESC_W'(1) : presc_i;
  assign half      = ({1'b0, presc_eff} + 1'b1) >> 1;

  always_comb begin
    if (!run_i)                 cnt_d = '0;
    else if (cnt_q == presc_eff) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
    sclk_d = run_i && gate_i && ({1'b0, cnt_d} >= half);
  end

  assign rise_o = run_i && gate_i && ({1'b0, cnt_q} == half - 1'b1);
  assign end_o  = run_i && (cnt_q == presc_eff);
  assign sclk_o = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= presc_eff)); // R9
  AST_RISE_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $past(rise_o)); // R9
endmodule

// File: rtl/qspi_seq_engine.sv
`timescale 1ns/1ps
module qspi_seq_engine
  import qspi_seq_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [31:0]      cmd_i,
  input  logic [31:0]      addr_i,
  input  logic [LEN_W-1:0] dlen_i,
  input  logic             rise_i,
  input  logic             end_i,
  input  logic             sshift_i,
  input  logic [3:0]       io_in_i,
  input  logic [7:0]       tx_data_i,
  output logic             busy_o,
  output logic             gate_o,
  output logic [3:0]       io_out_o,
  output logic [3:0]       io_oe_o,
  output logic             tx_pop_o,
  output logic             rx_push_o,
  output logic [7:0]       rx_data_o
);
  phase_e           ph_q, ph_d, tgt;
  logic [31:0]      sr_q, sr_d;
  logic [5:0]       cl_q, cl_d;
  logic [LEN_W-1:0] bl_q, bl_d;
  logic [7:0]       rxs_q, rxs_d, rxd_q, rxd_d;
  logic             push_q, push_d;
  logic             load, pop, rd, sample, drive;
  logic [1:0]       cur_mode, cur_l, asz;
  logic [2:0]       step;

  assign rd  = (cmd_i[27:26] == 2'd1);
  assign asz = cmd_i[13:12];

  always_comb begin
    case (ph_q)
      PH_INSTR: cur_mode = cmd_i[9:8];
      PH_ADDR:  cur_mode = cmd_i[11:10];
      PH_DATA:  cur_mode = cmd_i[25:24];
      default:  cur_mode = 2'd0;
    endcase
    cur_l = lanes_log2(cur_mode);
    step  = 3'd1 << cur_l;
  end

  always_comb begin
    ph_d = ph_q; sr_d = sr_q; cl_d = cl_q; bl_d = bl_q;
    rxs_d = rxs_q; rxd_d = rxd_q; push_d = 1'b0;
    pop = 1'b0; load = 1'b0; tgt = PH_IDLE;
    sample = (ph_q == PH_DATA) && rd && (sshift_i ? end_i : rise_i);
    if (sample) begin
      case (cur_l)
        2'd0:    rxs_d = {rxs_q[6:0], io_in_i[1]};
        2'd1:    rxs_d = {rxs_q[5:0], io_in_i[1:0]};
        default: rxs_d = {rxs_q[3:0], io_in_i};
      endcase
    end
    if (ph_q == PH_IDLE) begin
      if (start_i) begin
        load = 1'b1;
        tgt  = next_phase(PH_IDLE, cmd_i);
      end
    end else if (end_i) begin
      if (ph_q == PH_TAIL) begin
        ph_d = PH_IDLE;
      end else if (cl_q != 6'd0) begin
        cl_d = cl_q - 1'b1;
        sr_d = sr_q << step;
      end else if (ph_q == PH_DATA) begin
        if (rd) begin
          push_d = 1'b1;
          rxd_d  = rxs_d;
        end
        load = 1'b1;
        if (bl_q == '0) tgt = next_phase(PH_DATA, cmd_i);
        else begin
          bl_d = bl_q - 1'b1;
          tgt  = PH_DATA;
        end
      end else begin
        load = 1'b1;
        tgt  = next_phase(ph_q, cmd_i);
      end
    end
    if (load) begin
      ph_d = tgt;
      case (tgt)
        PH_INSTR: begin
          sr_d = {cmd_i[7:0], 24'h0};
          cl_d = (6'd8 >> lanes_log2(cmd_i[9:8])) - 1'b1;
        end
        PH_ADDR: begin
          sr_d = addr_i << {2'd3 - asz, 3'b000};
          cl_d = (({4'd0, asz} + 6'd1) << 3 >> lanes_log2(cmd_i[11:10])) - 1'b1;
        end
        PH_DUMMY: cl_d = {1'b0, cmd_i[22:18]} - 1'b1;
        PH_DATA: begin
          sr_d = {tx_data_i, 24'h0};
          pop  = !rd;
          cl_d = (6'd8 >> lanes_log2(cmd_i[25:24])) - 1'b1;
          if (ph_q != PH_DATA) bl_d = dlen_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; sr_q <= '0; cl_q <= '0; bl_q <= '0;
      rxs_q <= '0; rxd_q <= '0; push_q <= 1'b0;
    end else begin
      ph_q <= ph_d; sr_q <= sr_d; cl_q <= cl_d; bl_q <= bl_d;
      rxs_q <= rxs_d; rxd_q <= rxd_d; push_q <= push_d;
    end
  end

  assign drive = (ph_q == PH_INSTR) || (ph_q == PH_ADDR) || (ph_q == PH_DATA && !rd);
  always_comb begin
    case (cur_l)
      2'd0:    begin io_out_o = {3'b000, sr_q[31]};    io_oe_o = drive ? 4'b0001 : 4'b0000; end
      2'd1:    begin io_out_o = {2'b00, sr_q[31:30]};  io_oe_o = drive ? 4'b0011 : 4'b0000; end
      default: begin io_out_o = sr_q[31:28];           io_oe_o = drive ? 4'b1111 : 4'b0000; end
    endcase
  end

  assign busy_o    = (ph_q != PH_IDLE);
  assign gate_o    = (ph_q == PH_INSTR) || (ph_q == PH_ADDR) ||
                     (ph_q == PH_DUMMY) || (ph_q == PH_DATA);
  assign tx_pop_o  = pop;
  assign rx_push_o = push_q;
  assign rx_data_o = rxd_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE) |-> (io_oe_o == 4'b0000)); // R1
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE && !end_i) |=> $stable(io_out_o)); // R4
  AST_PUSH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_o |-> $past(end_i)); // R8
  AST_TAIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_TAIL && end_i) |=> (ph_q == PH_IDLE)); // R12
endmodule

// File: rtl/qspi_cmd_seq.sv
`timescale 1ns/1ps
module qspi_cmd_seq
  import qspi_seq_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic        busy,
  output logic        sclk,
  output logic [1:0]  cs_n,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  input  logic [3:0]  io_in,
  output logic        tx_pop,
  input  logic [7:0]  tx_data,
  output logic        rx_push,
  output logic [7:0]  rx_data
);
  localparam int PRESC_W = 8;

  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_s_n;
  logic [31:0]            ctrl_q, ctrl_d, cmd_q, cmd_d, addr_q, addr_d;
  logic [LEN_W-1:0]       dlen_q, dlen_d;
  logic                   start_q, start_d, wr_ok, eng_busy, gate, rise, tick_end;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rs_q[SYNC_STAGES-1];

  always_comb begin
    wr_ok  = reg_wr && !eng_busy && !start_q;
    ctrl_d = ctrl_q; cmd_d = cmd_q; addr_d = addr_q; dlen_d = dlen_q;
    if (wr_ok) begin
      case (reg_sel)
        SEL_CTRL: ctrl_d = reg_wdata;
        SEL_CMD:  cmd_d  = reg_wdata;
        SEL_ADDR: addr_d = reg_wdata;
        default:  dlen_d = reg_wdata[LEN_W-1:0];
      endcase
    end
    start_d = wr_ok &&
      ((reg_sel == SEL_CMD  && !reg_wdata[27] && reg_wdata[11:10] == 2'd0) ||
       (reg_sel == SEL_ADDR && !cmd_q[27]     && cmd_q[11:10]     != 2'd0));
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_q <= '0; cmd_q <= '0; addr_q <= '0; dlen_q <= '0; start_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d; cmd_q <= cmd_d; addr_q <= addr_d; dlen_q <= dlen_d;
      start_q <= start_d;
    end
  end

  qspi_seq_clkgen #(.PRESC_W(PRESC_W)) i_clkgen (
    .clk(clk), .rst_n(rst_s_n), .run_i(eng_busy), .gate_i(gate),
    .presc_i(ctrl_q[31:24]), .rise_o(rise), .end_o(tick_end), .sclk_o(sclk)
  );

  qspi_seq_engine #(.LEN_W(LEN_W)) i_engine (
    .clk(clk), .rst_n(rst_s_n), .start_i(start_q), .cmd_i(cmd_q),
    .addr_i(addr_q), .dlen_i(dlen_q), .rise_i(rise), .end_i(tick_end),
    .sshift_i(ctrl_q[4]), .io_in_i(io_in), .tx_data_i(tx_data),
    .busy_o(eng_busy), .gate_o(gate), .io_out_o(io_out), .io_oe_o(io_oe),
    .tx_pop_o(tx_pop), .rx_push_o(rx_push), .rx_data_o(rx_data)
  );

  assign busy = eng_busy;
  assign cs_n = !eng_busy ? 2'b11 : (ctrl_q[7] ? 2'b01 : 2'b10);

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(~cs_n)); // R10
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_s_n)
    start_q |=> busy); // R2
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_s_n)
    !busy |-> !sclk); // R9
endmodule

// File: tb/test_qspi_cmd_seq.sv
`timescale 1ns/1ps
module test_qspi_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic        busy, sclk, tx_pop, rx_push;
  logic [1:0]  cs_n;
  logic [3:0]  io_out, io_oe, io_in;
  logic [7:0]  tx_data, rx_data;

  always #2 clk = ~clk;

  qspi_cmd_seq i_qspi_cmd_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .busy(busy), .sclk(sclk), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .tx_pop(tx_pop),
    .tx_data(tx_data), .rx_push(rx_push), .rx_data(rx_data)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // write FIFO model
  logic [7:0] tx_mem [0:255];
  int tx_idx = 0;
  assign tx_data = tx_mem[tx_idx[7:0]];
  always @(posedge clk) if (tx_pop) tx_idx <= tx_idx + 1;

  // read capture
  logic [7:0] rx_got [0:255];
  int rx_n = 0;
  always @(posedge clk) if (rx_push) begin
    rx_got[rx_n[7:0]] <= rx_data;
    rx_n <= rx_n + 1;
  end

  // flash model: records lanes at rising edges, changes read data after falling edges
  logic [3:0] cap_oe [0:255], cap_out [0:255];
  logic [1:0] cap_cs [0:255];
  realtime    cap_t [0:255];
  int cap_n = 0, fall_cnt = 0, fall_base = 0;
  realtime last_fall_t = 0, cs_rise_t = 0;
  logic [3:0] rd_nib [0:255];
  int tmp_idx;
  assign tmp_idx = fall_cnt - fall_base;
  assign io_in = rd_nib[tmp_idx[7:0]];

  always @(posedge sclk) begin
    cap_oe[cap_n[7:0]]  = io_oe;
    cap_out[cap_n[7:0]] = io_out;
    cap_cs[cap_n[7:0]]  = cs_n;
    cap_t[cap_n[7:0]]   = $realtime;
    cap_n++;
  end
  always @(negedge sclk) begin
    fall_cnt++;
    last_fall_t = $realtime;
  end
  always @(posedge cs_n[0] or posedge cs_n[1]) cs_rise_t = $realtime;

  // expected stream
  logic [3:0] exp_oe [0:255], exp_out [0:255];
  logic [7:0] exp_rx [0:255];
  int exp_n, exp_rx_n, exp_pops, cap_base, rx_base, pop_base;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [31:0] mk_cmd(input logic [7:0] op, input logic [1:0] im,
      input logic [1:0] am, input logic [1:0] asz, input logic [4:0] dc,
      input logic [1:0] dm, input logic [1:0] fm);
    return {4'h0, fm, dm, 1'b0, dc, 4'h0, asz, am, im, op};
  endfunction

  function automatic int lanes(input logic [1:0] m);
    return (m == 2'd3) ? 4 : int'(m);
  endfunction

  function automatic logic [3:0] place(input logic [3:0] bits, input int w, input bit rx);
    if (w == 1) return rx ? {2'b00, bits[0], 1'b0} : {3'b000, bits[0]};
    if (w == 2) return {2'b00, bits[1:0]};
    return bits;
  endfunction

  task automatic begin_txn();
    exp_n = 0; exp_rx_n = 0; exp_pops = 0;
    cap_base = cap_n; rx_base = rx_n; pop_base = tx_idx; fall_base = fall_cnt;
    for (int i = 0; i < 256; i++) rd_nib[i] = 4'h0;
  endtask

  task automatic exp_bits(input logic [31:0] v, input int nbits, input logic [1:0] m);
    int w = lanes(m);
    logic [31:0] vv = v << (32 - nbits);
    for (int k = 0; k < nbits / w; k++) begin
      exp_oe[exp_n]  = (w == 1) ? 4'b0001 : (w == 2) ? 4'b0011 : 4'b1111;
      exp_out[exp_n] = place(vv[31:28] >> (4 - w), w, 1'b0);
      vv = vv << w;
      exp_n++;
    end
  endtask

  task automatic exp_dummy(input int n);
    for (int k = 0; k < n; k++) begin
      exp_oe[exp_n] = 4'b0000; exp_out[exp_n] = 4'b0000; exp_n++;
    end
  endtask

  task automatic exp_wbyte(input logic [7:0] b, input logic [1:0] m);
    tx_mem[8'(pop_base + exp_pops)] = b;
    exp_pops++;
    exp_bits({24'h0, b}, 8, m);
  endtask

  task automatic exp_rbyte(input logic [7:0] b, input logic [1:0] m);
    int w = lanes(m);
    logic [7:0] bb = b;
    for (int k = 0; k < 8 / w; k++) begin
      rd_nib[exp_n] = place(bb[7:4] >> (4 - w), w, 1'b1);
      bb = bb << w;
      exp_oe[exp_n] = 4'b0000; exp_out[exp_n] = 4'b0000; exp_n++;
    end
    exp_rx[exp_rx_n] = b; exp_rx_n++;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    repeat (4) @(negedge clk);
    while (busy && n < 4000) begin @(negedge clk); n++; end
    chk(!busy, req, "command did not finish", busy, 0);
    repeat (2) @(negedge clk);
  endtask

  // compare captured command against the expected stream
  task automatic finish_txn(input string req, input int presc, input logic [1:0] cs_exp);
    int per_ns = ((presc == 0) ? 2 : presc + 1) * 4;
    int bad = -1;
    chk(cap_n - cap_base == exp_n, req, "rising edge count", cap_n - cap_base, exp_n);
    for (int k = 0; k < exp_n; k++) begin
      int j = (cap_base + k) % 256;
      if (bad < 0 && (cap_oe[j] != exp_oe[k] || (cap_out[j] & exp_oe[k]) != exp_out[k] ||
                      cap_cs[j] != cs_exp)) bad = k;
    end
    if (bad >= 0) begin
      int j = (cap_base + bad) % 256;
      chk(1'b0, req, $sformatf("edge %0d {cs,oe,out}", bad),
          {cap_cs[j], cap_oe[j], cap_out[j]}, {cs_exp, exp_oe[bad], exp_out[bad]});
    end else chk(1'b1, req, "lane stream", 0, 0);
    if (exp_n >= 2)
      chk(int'(cap_t[(cap_base + 1) % 256] - cap_t[cap_base % 256]) == per_ns, "R9",
          "serial period ns", int'(cap_t[(cap_base + 1) % 256] - cap_t[cap_base % 256]), per_ns);
    chk(int'(cs_rise_t - last_fall_t) == per_ns, "R12", "chip select release ns",
        int'(cs_rise_t - last_fall_t), per_ns);
    chk(tx_idx - pop_base == exp_pops, "R7", "FIFO pops", tx_idx - pop_base, exp_pops);
    chk(rx_n - rx_base == exp_rx_n, "R8", "read byte count", rx_n - rx_base, exp_rx_n);
    for (int k = 0; k < exp_rx_n && k < rx_n - rx_base; k++)
      chk(rx_got[(rx_base + k) % 256] == exp_rx[k], "R8", $sformatf("read byte %0d", k),
          rx_got[(rx_base + k) % 256], exp_rx[k]);
  endtask

  task automatic t_reset();
    chk(cs_n == 2'b11, "R1", "cs_n after reset", cs_n, 2'b11);
    chk(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(io_oe == 4'b0000, "R1", "io_oe after reset", io_oe, 0);
  endtask

  // single-lane write: opcode, 3-byte address, 2 data bytes; R3 R4 R5 R7
  task automatic t_write_single();
    begin_txn();
    exp_bits(32'h02, 8, 2'd1);
    exp_bits(32'h123456, 24, 2'd1);
    exp_wbyte(8'hA5, 2'd1);
    exp_wbyte(8'h3C, 2'd1);
    wr(2'd0, {8'd3, 24'h0});
    wr(2'd3, 32'd1);
    wr(2'd1, mk_cmd(8'h02, 2'd1, 2'd1, 2'd2, 5'd0, 2'd1, 2'd0));
    repeat (6) @(negedge clk);
    chk(!busy && cs_n == 2'b11, "R2", "started before address write", busy, 0);
    wr(2'd2, 32'hAB123456);
    wait_idle("R3");
    finish_txn("R5", 3, 2'b10);
  endtask

  // quad address, 6 turnaround clocks, quad read of 4 bytes; R4 R6 R8
  task automatic t_read_quad();
    begin_txn();
    exp_bits(32'hEB, 8, 2'd1);
    exp_bits(32'hDEADBEEF, 32, 2'd3);
    exp_dummy(6);
    exp_rbyte(8'h11, 2'd3); exp_rbyte(8'hC7, 2'd3);
    exp_rbyte(8'h5E, 2'd3); exp_rbyte(8'h90, 2'd3);
    wr(2'd0, {8'd1, 24'h0});
    wr(2'd3, 32'd3);
    wr(2'd1, mk_cmd(8'hEB, 2'd1, 2'd3, 2'd3, 5'd6, 2'd3, 2'd1));
    wr(2'd2, 32'hDEADBEEF);
    wait_idle("R6");
    finish_txn("R4", 1, 2'b10);
  endtask

  // dual opcode and read, no address, bank 1, late sampling; R10 R11 R2
  task automatic t_dual_shift();
    begin_txn();
    exp_bits(32'h3B, 8, 2'd2);
    exp_dummy(4);
    exp_rbyte(8'h69, 2'd2); exp_rbyte(8'hF0, 2'd2);
    wr(2'd0, {8'd2, 16'h0, 8'h90});
    wr(2'd3, 32'd1);
    wr(2'd1, mk_cmd(8'h3B, 2'd2, 2'd0, 2'd0, 5'd4, 2'd2, 2'd1));
    wait_idle("R11");
    finish_txn("R10", 2, 2'b01);
  endtask

  // opcode-only command with prescaler 0; R9 R3
  task automatic t_instr_only();
    begin_txn();
    exp_bits(32'h06, 8, 2'd1);
    wr(2'd0, 32'h0);
    wr(2'd1, mk_cmd(8'h06, 2'd1, 2'd0, 2'd0, 5'd0, 2'd0, 2'd0));
    wait_idle("R3");
    finish_txn("R9", 0, 2'b10);
  endtask

  // modes 2 and 3 never start; R2
  task automatic t_ignored_modes();
    int e0 = cap_n;
    wr(2'd1, mk_cmd(8'h05, 2'd1, 2'd0, 2'd0, 5'd0, 2'd1, 2'd2));
    repeat (20) @(negedge clk);
    chk(!busy && cs_n == 2'b11, "R2", "polling mode started", {busy, cs_n}, 3);
    wr(2'd1, mk_cmd(8'h0B, 2'd1, 2'd1, 2'd2, 5'd0, 2'd1, 2'd3));
    wr(2'd2, 32'h000100);
    repeat (20) @(negedge clk);
    chk(!busy && cap_n == e0, "R2", "mapped mode started (edges)", cap_n - e0, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin tx_mem[i] = 8'h00; rd_nib[i] = 4'h0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_single();
    t_read_quad();
    t_dual_shift();
    t_instr_only();
    t_ignored_modes();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule